// File: doc/BRIEF.md
# Thirty-Two-Register Accumulator CPU Core

This is a small multicycle processor. Program and data share a single memory of 256 instruction words. Each word carries its own successor address, so the core never steps a program counter by one. Operands sit in a file of 32 eight-bit registers. The ALU always takes its first operand from r0 and its second from the register named by field A. A loop unit is tied to r31. It can clear or step r31, and it steers compare instructions to an alternate address according to how r31 relates to register A.

Execution uses two cycles per instruction. In `S_FETCH` the word at the program counter is latched. In `S_EXEC` it is carried out, one register write at most is made, and the program counter is loaded. The other two states are `S_HALT`, where the core idles after a halt, and `S_PROG`, where the program port may write memory.

The transitions are as follows:
- Reset leads to `S_FETCH`.
- `S_FETCH` goes to `S_EXEC`.
- `S_EXEC` goes to `S_FETCH`. It goes to `S_HALT` on a halt and to `S_PROG` on the program-mode opcode.
- A raised `prog_req` moves `S_FETCH`, `S_EXEC` or `S_HALT` to `S_PROG`. An instruction in `S_EXEC` at that moment is abandoned.
- `prog_done` moves `S_PROG` to `S_FETCH`, with the program counter at 0.

A debug port reads any register at any time.

Top module: `lcpu_core`

## Requirements
- R1: A synchronous active-high `rst` clears all 32 registers, sets the program counter to 0, lowers `halted` and sets the loop unit to count mode. The core then starts in `S_FETCH`. While reset is held, a high `prog_req` makes the first clock after release enter `S_PROG`.
- R2: The instruction word is 39 bits, laid out as follows:
  - op in [38:34]
  - A in [33:29]
  - B in [28:24]
  - data in [23:16]
  - next address in [15:8]
  - alternate address in [7:0]

  LOAD (op 0) writes the data field into register A. MOVE (op 1) copies register A into register B.
- R3: OR (12), XOR (13), AND (14) and ADD (15) combine r0 with register A and write the result into register B. ADD wraps modulo 256.
- R4: SUB (16) writes r0 minus register A, modulo 256, into register B. INV (11) writes the bitwise inverse of r0 into register A.
- R5: EXT (2) writes the `ext_in` value into register A.
- R6: Every instruction that does not jump continues at its next-address field. Each instruction takes exactly two clocks. A program of k instructions followed by HLT raises `halted` 2(k+1) clocks after the program starts.
- R7: JGT (6), JLT (7) and JEQ (8) go to the alternate address when r31 is greater than, less than or equal to register A, compared as unsigned values. Otherwise they go to the next address.
- R8: The loop unit handles three opcodes:
  - LCRST (3) clears r31 in either mode.
  - LCINC (4) increments r31 modulo 256 in count mode and has no effect in compare mode.
  - LCTGL (5) flips the mode.
- R9: HLT (9) sets `halted`. Registers and `halted` then stay unchanged until reset or `prog_req`.
- R10: `prog_req` enters programming mode from any running or halted state, and so does opcode PRGM (10). In programming mode each `prog_we` clock stores `prog_wdata` at `prog_addr`, and no instruction runs. `prog_done` resumes execution at address 0. A `prog_we` outside programming mode is ignored.
- R11: Opcodes 17 to 31 write no register and continue at the next address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_in | input | 8 | External data read by EXT |
| prog_req | input | 1 | Request programming mode |
| prog_done | input | 1 | Leave programming mode, restart at 0 |
| prog_we | input | 1 | Memory write strobe, used in programming mode |
| prog_addr | input | 8 | Memory write address |
| prog_wdata | input | 39 | Instruction word to store |
| halted | output | 1 | High while the core is stopped by HLT |
| dbg_sel | input | 5 | Register index for read-out |
| dbg_data | output | 8 | Contents of the selected register |

## Verification
The hardest state to reach from the ports is programming mode entered by the PRGM opcode rather than by `prog_req`. From outside it looks exactly like a stalled core. The stimulus runs a program that writes a marker, executes PRGM and would then overwrite the marker. The bench confirms that the marker survives while `halted` stays low. It then writes a new program with no `prog_req` at all and shows that program running after `prog_done`. Compare mode of the loop unit is reached in the same way: an LCTGL is followed by an LCINC whose absence shows up in r31, and reset is asserted while the unit is in compare mode.

// File: rtl/lcpu_pkg.sv
package lcpu_pkg;
    localparam int DW   = 8;
    localparam int AW   = 8;
    localparam int NREG = 32;
    localparam int RSW  = $clog2(NREG);
    localparam int OPW  = 5;
    localparam int IW   = OPW + 2 * RSW + DW + 2 * AW;

    typedef enum logic [OPW-1:0] {
        OP_LOAD  = 5'd0,  OP_MOVE = 5'd1,  OP_EXT   = 5'd2,  OP_LCRST = 5'd3,
        OP_LCINC = 5'd4,  OP_LCTGL = 5'd5, OP_JGT   = 5'd6,  OP_JLT   = 5'd7,
        OP_JEQ   = 5'd8,  OP_HLT  = 5'd9,  OP_PRGM  = 5'd10, OP_INV   = 5'd11,
        OP_OR    = 5'd12, OP_XOR  = 5'd13, OP_AND   = 5'd14, OP_ADD   = 5'd15,
        OP_SUB   = 5'd16
    } opcode_e;

    typedef enum logic [1:0] {S_PROG, S_FETCH, S_EXEC, S_HALT} state_e;

    typedef struct packed {
        logic [OPW-1:0] op;
        logic [RSW-1:0] ra;
        logic [RSW-1:0] rb;
        logic [DW-1:0]  data;
        logic [AW-1:0]  nxt;
        logic [AW-1:0]  alt;
    } instr_t;
endpackage

// File: rtl/lcpu_regfile.sv
module lcpu_regfile #(
    parameter int DW   = 8,
    parameter int NREG = 32,
    localparam int RSW = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [RSW-1:0] waddr,
    input  logic [DW-1:0]  wdata,
    input  logic [RSW-1:0] raddr_a,
    input  logic [RSW-1:0] dbg_sel,
    output logic [DW-1:0]  rdata_a,
    output logic [DW-1:0]  r_first,
    output logic [DW-1:0]  r_last,
    output logic [DW-1:0]  dbg_data
);
    logic [DW-1:0] q [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                q[i] <= '0;
            else if (we && waddr == RSW'(i))
                q[i] <= wdata;
        end
    end

    assign rdata_a  = q[raddr_a];
    assign r_first  = q[0];
    assign r_last   = q[NREG-1];
    assign dbg_data = q[dbg_sel];

    // R2: a write is visible at its address on the next cycle
    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        we |=> q[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/lcpu_alu.sv
module lcpu_alu
    import lcpu_pkg::*;
(
    input  opcode_e       op,
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] y,
    input  logic [DW-1:0] imm,
    input  logic [DW-1:0] ext,
    output logic [DW-1:0] res,
    output logic          wr,
    output logic          to_b
);
    always_comb begin
        res  = '0;
        wr   = 1'b0;
        to_b = 1'b0;
        unique case (op)
            OP_LOAD: begin res = imm;     wr = 1'b1;              end
            OP_MOVE: begin res = y;       wr = 1'b1; to_b = 1'b1; end
            OP_EXT:  begin res = ext;     wr = 1'b1;              end
            OP_INV:  begin res = ~x;      wr = 1'b1;              end
            OP_OR:   begin res = x | y;   wr = 1'b1; to_b = 1'b1; end
            OP_XOR:  begin res = x ^ y;   wr = 1'b1; to_b = 1'b1; end
            OP_AND:  begin res = x & y;   wr = 1'b1; to_b = 1'b1; end
            OP_ADD:  begin res = x + y;   wr = 1'b1; to_b = 1'b1; end
            OP_SUB:  begin res = x - y;   wr = 1'b1; to_b = 1'b1; end
            default: ;
        endcase
    end
endmodule

// File: rtl/lcpu_loop.sv
module lcpu_loop
    import lcpu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          exec,
    input  opcode_e       op,
    input  logic [DW-1:0] cnt,
    input  logic [DW-1:0] other,
    output logic          lc_we,
    output logic [DW-1:0] lc_val,
    output logic          take,
    output logic          count_mode
);
    logic tgl;
    assign tgl = exec && op == OP_LCTGL;

    always_ff @(posedge clk) begin
        if (rst)
            count_mode <= 1'b1;
        else if (tgl)
            count_mode <= ~count_mode;
    end

    always_comb begin
        lc_we  = 1'b0;
        lc_val = '0;
        take   = 1'b0;
        if (exec) begin
            unique case (op)
                OP_LCRST: lc_we = 1'b1;
                OP_LCINC: begin lc_we = count_mode; lc_val = cnt + 1'b1; end
                OP_JGT:   take = cnt > other;
                OP_JLT:   take = cnt < other;
                OP_JEQ:   take = cnt == other;
                default:  ;
            endcase
        end
    end

    // R8: every LCTGL flips the mode
    a_r8_mode_flips: assert property (@(posedge clk) disable iff (rst)
        tgl |=> count_mode != $past(count_mode));
    // R8: compare mode never steps the counter
    a_r8_no_step_in_compare: assert property (@(posedge clk) disable iff (rst)
        (exec && op == OP_LCINC && !count_mode) |-> !lc_we);
endmodule

// File: rtl/lcpu_core.sv
module lcpu_core
    import lcpu_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [DW-1:0]  ext_in,
    input  logic           prog_req,
    input  logic           prog_done,
    input  logic           prog_we,
    input  logic [AW-1:0]  prog_addr,
    input  logic [IW-1:0]  prog_wdata,
    output logic           halted,
    input  logic [RSW-1:0] dbg_sel,
    output logic [DW-1:0]  dbg_data
);
    localparam int DEPTH = 1 << AW;

    state_e        state, state_nx;
    logic [AW-1:0] pc;
    instr_t        ir;
    opcode_e       cur_op;
    logic [IW-1:0] mem [DEPTH];

    logic          exec;
    logic [DW-1:0] ra_val, r0_val, r31_val;
    logic [DW-1:0] alu_res, lc_val, rf_wdata;
    logic          alu_wr, alu_to_b, lc_we, take, count_mode;
    logic          rf_we;
    logic [RSW-1:0] rf_waddr;

    assign cur_op = opcode_e'(ir.op);
    assign exec   = state == S_EXEC && !prog_req;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= S_FETCH;
        else     state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_PROG:  state_nx = prog_done ? S_FETCH : S_PROG;
            S_FETCH: state_nx = prog_req ? S_PROG : S_EXEC;
            S_EXEC: begin
                if (prog_req)               state_nx = S_PROG;
                else if (cur_op == OP_HLT)  state_nx = S_HALT;
                else if (cur_op == OP_PRGM) state_nx = S_PROG;
                else                        state_nx = S_FETCH;
            end
            S_HALT:  state_nx = prog_req ? S_PROG : S_HALT;
        endcase
    end

    // outputs and register-file write
    always_comb begin
        halted   = state == S_HALT;
        rf_we    = 1'b0;
        rf_waddr = ir.ra;
        rf_wdata = alu_res;
        if (exec) begin
            if (lc_we) begin
                rf_we    = 1'b1;
                rf_waddr = RSW'(NREG - 1);
                rf_wdata = lc_val;
            end else if (alu_wr) begin
                rf_we    = 1'b1;
                rf_waddr = alu_to_b ? ir.rb : ir.ra;
            end
        end
    end

    // sequencing and memory
    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
            ir <= '0;
        end else begin
            if (state == S_FETCH)
                ir <= mem[pc];
            if (state == S_PROG && prog_done)
                pc <= '0;
            else if (exec)
                pc <= take ? ir.alt : ir.nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (state == S_PROG && prog_we)
            mem[prog_addr] <= prog_wdata;
    end

    lcpu_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk(clk), .rst(rst), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
        .raddr_a(ir.ra), .dbg_sel(dbg_sel), .rdata_a(ra_val),
        .r_first(r0_val), .r_last(r31_val), .dbg_data(dbg_data)
    );

    lcpu_alu u_alu (
        .op(cur_op), .x(r0_val), .y(ra_val), .imm(ir.data), .ext(ext_in),
        .res(alu_res), .wr(alu_wr), .to_b(alu_to_b)
    );

    lcpu_loop u_loop (
        .clk(clk), .rst(rst), .exec(exec), .op(cur_op), .cnt(r31_val),
        .other(ra_val), .lc_we(lc_we), .lc_val(lc_val), .take(take),
        .count_mode(count_mode)
    );

    // R9: a halted core stays halted until a programming request
    a_r9_halt_holds: assert property (@(posedge clk) disable iff (rst)
        (state == S_HALT && !prog_req) |=> (state == S_HALT && halted));
    // R10: releasing programming mode restarts at address 0
    a_r10_resume_at_zero: assert property (@(posedge clk) disable iff (rst)
        (state == S_PROG && prog_done) |=> (state == S_FETCH && pc == '0));
    // R10: no register changes outside execution
    a_r10_quiet_outside_exec: assert property (@(posedge clk) disable iff (rst)
        (state != S_EXEC) |-> !rf_we);
    // R7: an equal compare lands on the alternate address
    a_r7_eq_jump: assert property (@(posedge clk) disable iff (rst)
        (exec && cur_op == OP_JEQ && ra_val == r31_val) |=> pc == $past(ir.alt));
endmodule

// File: tb/lcpu_core_tb.sv
module lcpu_core_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  ext_in = '0;
    logic        prog_req = 1'b0, prog_done = 1'b0, prog_we = 1'b0;
    logic [7:0]  prog_addr = '0;
    logic [38:0] prog_wdata = '0;
    logic        halted;
    logic [4:0]  dbg_sel = '0;
    logic [7:0]  dbg_data;

    int errors = 0;
    int checks = 0;
    logic [38:0] prog [16];

    always #2.5 clk = ~clk;

    lcpu_core u_dut (
        .clk(clk), .rst(rst), .ext_in(ext_in), .prog_req(prog_req),
        .prog_done(prog_done), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_wdata(prog_wdata), .halted(halted), .dbg_sel(dbg_sel),
        .dbg_data(dbg_data)
    );

    function automatic logic [38:0] w(int op, int a, int b, int d, int n, int al);
        return {op[4:0], a[4:0], b[4:0], d[7:0], n[7:0], al[7:0]};
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic rd(int idx, output int v);
        dbg_sel = idx[4:0];
        #1;
        v = int'(dbg_data);
    endtask

    task automatic chk_reg(int idx, int exp, string req);
        int v;
        rd(idx, v);
        check(v == exp, req, v, exp);
    endtask

    task automatic enter_prog();
        @(negedge clk) prog_req = 1'b1;
        @(negedge clk) prog_req = 1'b0;
    endtask

    task automatic put(int addr, logic [38:0] word);
        @(negedge clk);
        prog_we = 1'b1; prog_addr = addr[7:0]; prog_wdata = word;
        @(negedge clk) prog_we = 1'b0;
    endtask

    task automatic leave_prog();
        @(negedge clk) prog_done = 1'b1;
        @(negedge clk) prog_done = 1'b0;
    endtask

    task automatic wait_halt(output int cyc);
        cyc = 0;
        while (!halted && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic load_run(int n, string req);
        int cyc;
        enter_prog();
        for (int i = 0; i < n; i++) put(i, prog[i]);
        leave_prog();
        wait_halt(cyc);
        check(halted == 1'b1, req, int'(halted), 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int v, cyc;
        int vals [6] = '{0, 1, 127, 128, 254, 255};

        // R1: reset state, held with prog_req so nothing runs from memory
        prog_req = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk) prog_req = 1'b0;
        check(halted == 1'b0, "R1 halted", int'(halted), 0);
        for (int i = 0; i < 32; i++) chk_reg(i, 0, "R1 reg clear");

        // R2 LOAD/MOVE and R6 timing: three instructions then HLT
        prog[0] = w(0, 3, 0, 8'h5C, 1, 0);
        prog[1] = w(1, 3, 9, 0, 2, 0);
        prog[2] = w(0, 10, 0, 8'h21, 3, 0);
        prog[3] = w(9, 0, 0, 0, 3, 0);
        enter_prog();
        for (int i = 0; i < 4; i++) put(i, prog[i]);
        leave_prog();
        wait_halt(cyc);
        check(cyc == 8, "R6 two cycles per instruction", cyc, 8);
        chk_reg(3, 8'h5C, "R2 LOAD");
        chk_reg(9, 8'h5C, "R2 MOVE");
        chk_reg(10, 8'h21, "R2 LOAD second");

        // R6: next-address field skips words
        prog[0] = w(0, 11, 0, 7, 5, 0);
        prog[1] = w(0, 11, 0, 9, 2, 0);
        prog[2] = w(9, 0, 0, 0, 2, 0);
        prog[3] = w(9, 0, 0, 0, 3, 0);
        prog[4] = w(9, 0, 0, 0, 4, 0);
        prog[5] = w(9, 0, 0, 0, 5, 0);
        load_run(6, "R6 halt");
        chk_reg(11, 7, "R6 next address");

        // R9: halt holds registers and flag
        repeat (12) @(negedge clk);
        check(halted == 1'b1, "R9 halt sticky", int'(halted), 1);
        chk_reg(11, 7, "R9 reg held");

        // R3, R4: sweep over r0 and register A values
        for (int op = 12; op <= 16; op++) begin
            for (int i = 0; i < 16; i++) begin
                for (int j = 0; j < 16; j++) begin
                    int x, y, e;
                    x = i * 17;
                    y = (j * 17 + 3) % 256;
                    case (op)
                        12: e = x | y;
                        13: e = x ^ y;
                        14: e = x & y;
                        15: e = (x + y) % 256;
                        default: e = (x - y + 256) % 256;
                    endcase
                    prog[0] = w(0, 0, 0, x, 1, 0);
                    prog[1] = w(0, 1, 0, y, 2, 0);
                    prog[2] = w(op, 1, 2, 0, 3, 0);
                    prog[3] = w(9, 0, 0, 0, 3, 0);
                    load_run(4, op == 16 ? "R4 halt" : "R3 halt");
                    chk_reg(2, e, op == 16 ? "R4 SUB" : "R3 logic/add");
                end
            end
        end
        for (int i = 0; i < 16; i++) begin
            prog[0] = w(0, 0, 0, i * 17 + 1, 1, 0);
            prog[1] = w(11, 6, 0, 0, 2, 0);
            prog[2] = w(9, 0, 0, 0, 2, 0);
            load_run(3, "R4 halt");
            chk_reg(6, 255 - ((i * 17 + 1) % 256), "R4 INV");
        end

        // R5: external input
        ext_in = 8'hA5;
        prog[0] = w(2, 4, 0, 0, 1, 0);
        prog[1] = w(9, 0, 0, 0, 1, 0);
        load_run(2, "R5 halt");
        chk_reg(4, 8'hA5, "R5 EXT");

        // R7: compare sweep
        for (int c = 6; c <= 8; c++) begin
            for (int i = 0; i < 6; i++) begin
                for (int j = 0; j < 6; j++) begin
                    bit tk;
                    tk = (c == 6) ? (vals[i] > vals[j]) :
                         (c == 7) ? (vals[i] < vals[j]) : (vals[i] == vals[j]);
                    prog[0] = w(0, 31, 0, vals[i], 1, 0);
                    prog[1] = w(0, 1, 0, vals[j], 2, 0);
                    prog[2] = w(c, 1, 0, 0, 3, 4);
                    prog[3] = w(0, 2, 0, 8'h11, 5, 0);
                    prog[4] = w(0, 2, 0, 8'h22, 5, 0);
                    prog[5] = w(9, 0, 0, 0, 5, 0);
                    load_run(6, "R7 halt");
                    chk_reg(2, tk ? 8'h22 : 8'h11, "R7 compare jump");
                end
            end
        end

        // R8: loop unit
        prog[0] = w(3, 0, 0, 0, 1, 0);
        prog[1] = w(4, 0, 0, 0, 2, 0);
        prog[2] = w(4, 0, 0, 0, 3, 0);
        prog[3] = w(4, 0, 0, 0, 4, 0);
        prog[4] = w(9, 0, 0, 0, 4, 0);
        load_run(5, "R8 halt");
        chk_reg(31, 3, "R8 count");
        prog[0] = w(5, 0, 0, 0, 1, 0);
        prog[1] = w(4, 0, 0, 0, 2, 0);
        prog[2] = w(5, 0, 0, 0, 3, 0);
        prog[3] = w(4, 0, 0, 0, 4, 0);
        load_run(5, "R8 halt");
        chk_reg(31, 4, "R8 compare mode ignores step");
        prog[0] = w(0, 31, 0, 255, 1, 0);
        prog[1] = w(4, 0, 0, 0, 2, 0);
        prog[2] = w(9, 0, 0, 0, 2, 0);
        load_run(3, "R8 halt");
        chk_reg(31, 0, "R8 wrap");
        prog[0] = w(0, 31, 0, 9, 1, 0);
        prog[1] = w(5, 0, 0, 0, 2, 0);
        prog[2] = w(3, 0, 0, 0, 3, 0);
        prog[3] = w(9, 0, 0, 0, 3, 0);
        load_run(4, "R8 halt");
        chk_reg(31, 0, "R8 clear in compare mode");

        // R1: reset mid-life while in compare mode
        @(negedge clk);
        rst = 1'b1; prog_req = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk) prog_req = 1'b0;
        chk_reg(11, 0, "R1 reset clears");
        chk_reg(2, 0, "R1 reset clears");
        check(halted == 1'b0, "R1 halted after reset", int'(halted), 0);
        put(0, w(4, 0, 0, 0, 1, 0));
        put(1, w(9, 0, 0, 0, 1, 0));
        leave_prog();
        wait_halt(cyc);
        chk_reg(31, 1, "R1 count mode after reset");

        // R11: unused opcode
        prog[0] = w(0, 7, 0, 5, 1, 0);
        prog[1] = w(20, 7, 7, 8'h99, 2, 0);
        prog[2] = w(9, 0, 0, 0, 2, 0);
        load_run(3, "R11 halt");
        chk_reg(7, 5, "R11 no write");

        // R10: PRGM opcode enters programming mode
        prog[0] = w(0, 5, 0, 1, 1, 0);
        prog[1] = w(10, 0, 0, 0, 2, 0);
        prog[2] = w(0, 5, 0, 2, 3, 0);
        prog[3] = w(9, 0, 0, 0, 3, 0);
        enter_prog();
        for (int i = 0; i < 4; i++) put(i, prog[i]);
        leave_prog();
        repeat (20) @(negedge clk);
        check(halted == 1'b0, "R10 PRGM not halted", int'(halted), 0);
        chk_reg(5, 1, "R10 PRGM stops execution");
        put(0, w(0, 5, 0, 3, 1, 0));
        put(1, w(9, 0, 0, 0, 1, 0));
        leave_prog();
        wait_halt(cyc);
        chk_reg(5, 3, "R10 write after PRGM");

        // R10: stray write outside programming mode is ignored
        prog[0] = w(0, 6, 0, 8'h10, 1, 0);
        prog[1] = w(9, 0, 0, 0, 1, 0);
        load_run(2, "R10 halt");
        put(0, w(0, 6, 0, 8'h77, 1, 0));
        chk_reg(6, 8'h10, "R10 stray write no effect");
        enter_prog();
        leave_prog();
        wait_halt(cyc);
        chk_reg(6, 8'h10, "R10 stray write ignored");

        // R10: prog_req interrupts a running loop
        prog[0] = w(0, 8, 0, 1, 0, 0);
        enter_prog();
        put(0, prog[0]);
        leave_prog();
        repeat (10) @(negedge clk);
        check(halted == 1'b0, "R10 looping", int'(halted), 0);
        prog[0] = w(0, 8, 0, 2, 1, 0);
        prog[1] = w(9, 0, 0, 0, 1, 0);
        load_run(2, "R10 prog_req while running");
        chk_reg(8, 2, "R10 reprogrammed");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule